// File: doc/BRIEF.md
# CPU System Register File

This block holds the control and status registers of a CPU core. Software reaches them through a 5-bit register number. A write port models the load-to-system-register operation. A combinational read port models the store-from-system-register operation. Each register has its own rule on whether it may be written, read, or neither.

Four classes of event make the block save the current program counter and status word into a save pair kept for that class. The classes are:
- a maskable interrupt or software exception;
- a non-maskable interrupt (NMI);
- a table-call instruction;
- an illegal-opcode trap.

The cause register is split into two 16-bit halves. The exception class writes its code into the lower half and the NMI class writes into the upper half. Each half keeps its value when the other is updated. Each save pair exists once, so a later event of the same class replaces what was saved before.

When several events arrive in one cycle, only the one with the highest priority is captured. The order, from highest, is NMI, trap, exception, table-call. A capture always takes precedence over a software write to the same register in that cycle.

Top module: `sysreg_bank`

## Requirements
- R1: After reset every register reads zero, except the status word (number 5), which reads the parameter PSW_RST (default 32'h0000_0020).
- R2: A write with wr_en high to number 0, 1, 2, 3, 5, 16, 17 or 20 is stored at the next rising clock edge. The new value then appears on rd_data whenever rd_num selects that number.
- R3: Writes to the cause register (number 4) and to the trap save pair (numbers 18, 19) are ignored. These registers can still be read.
- R4: Numbers 6 to 15 and 21 to 31 are reserved. Reading one returns zero, and writing one changes no register.
- R5: An exception event (ev_exc) copies cur_pc to number 0 and cur_psw to number 1. It puts exc_code into bits 15:0 of number 4 and leaves bits 31:16 unchanged.
- R6: An NMI event (ev_nmi) copies cur_pc to number 2 and cur_psw to number 3. It puts nmi_code into bits 31:16 of number 4 and leaves bits 15:0 unchanged.
- R7: A table-call event (ev_tcall) copies cur_pc to number 16 and cur_psw to number 17.
- R8: A trap event (ev_trap) copies cur_pc to number 18 and cur_psw to number 19.
- R9: When several events are raised in one cycle, only the highest-priority one is captured, in the order NMI, trap, exception, table-call. The save registers of the other events keep their values.
- R10: When a capture and a software write target the same register in one cycle, the captured value is stored.
- R11: status_word always equals the value of number 5.
- R12: A second event of the same class overwrites the values saved by the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data, combinational from rd_num |
| cur_pc | input | 32 | Current program counter to capture |
| cur_psw | input | 32 | Current status word to capture |
| ev_exc | input | 1 | Maskable interrupt or software exception |
| exc_code | input | 16 | Exception cause code |
| ev_nmi | input | 1 | Non-maskable interrupt |
| nmi_code | input | 16 | NMI cause code |
| ev_tcall | input | 1 | Table-call instruction executed |
| ev_trap | input | 1 | Illegal-opcode trap |
| status_word | output | 32 | Current value of the status word register |

## Verification
Writes go to every writable number with distinct data, so a decode that aliases two registers shows up as a wrong readback. The same distinct data is written to the locked and reserved numbers, and all 32 numbers are then swept. This separates a missing write lock from a wrong read of a reserved slot. Events are raised alone, then in pairs and all together, with distinct PC, PSW and code values. This shows whether the right pair was captured, whether the untouched half of the cause register was kept, and whether the priority order is right. A software write aimed at a register that a capture takes in the same cycle confirms that the capture prevails.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int NUM_W = 5;
  localparam int NUM_REGS = 1 << NUM_W;
  localparam int EV_N = 4;

  // Register numbers: decoded by software, kept fixed
  localparam logic [NUM_W-1:0] RN_EXC_PC   = 5'd0;
  localparam logic [NUM_W-1:0] RN_EXC_PSW  = 5'd1;
  localparam logic [NUM_W-1:0] RN_NMI_PC   = 5'd2;
  localparam logic [NUM_W-1:0] RN_NMI_PSW  = 5'd3;
  localparam logic [NUM_W-1:0] RN_CAUSE    = 5'd4;
  localparam logic [NUM_W-1:0] RN_PSW      = 5'd5;
  localparam logic [NUM_W-1:0] RN_TCL_PC   = 5'd16;
  localparam logic [NUM_W-1:0] RN_TCL_PSW  = 5'd17;
  localparam logic [NUM_W-1:0] RN_TRP_PC   = 5'd18;
  localparam logic [NUM_W-1:0] RN_TRP_PSW  = 5'd19;
  localparam logic [NUM_W-1:0] RN_TBASE    = 5'd20;

  // Event grant bit positions, lowest index = highest priority
  localparam int EVB_NMI  = 0;
  localparam int EVB_TRAP = 1;
  localparam int EVB_EXC  = 2;
  localparam int EVB_TCL  = 3;

  function automatic logic num_writable(input logic [NUM_W-1:0] n);
    case (n)
      RN_EXC_PC, RN_EXC_PSW, RN_NMI_PC, RN_NMI_PSW,
      RN_PSW, RN_TCL_PC, RN_TCL_PSW, RN_TBASE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic num_readable(input logic [NUM_W-1:0] n);
    return num_writable(n) || (n == RN_CAUSE) ||
           (n == RN_TRP_PC) || (n == RN_TRP_PSW);
  endfunction

  function automatic logic [EV_N-1:0] first_set(input logic [EV_N-1:0] r);
    return r & (~r + 1'b1);
  endfunction

endpackage

// File: rtl/sysreg_access.sv
module sysreg_access
  import sysreg_pkg::*;
(
  input  logic                wr_en,
  input  logic [NUM_W-1:0]    wr_num,
  output logic                wr_ok,
  output logic [NUM_REGS-1:0] wr_sel
);
  assign wr_ok = wr_en && num_writable(wr_num);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_sel
      assign wr_sel[g] = wr_ok && (wr_num == NUM_W'(g));
    end
  endgenerate
endmodule

// File: rtl/sysreg_event_arb.sv
module sysreg_event_arb
  import sysreg_pkg::*;
(
  input  logic            ev_nmi,
  input  logic            ev_trap,
  input  logic            ev_exc,
  input  logic            ev_tcall,
  output logic [EV_N-1:0] grant
);
  logic [EV_N-1:0] req;
  always_comb begin
    req = '0;
    req[EVB_NMI]  = ev_nmi;
    req[EVB_TRAP] = ev_trap;
    req[EVB_EXC]  = ev_exc;
    req[EVB_TCL]  = ev_tcall;
  end
  assign grant = first_set(req);
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] PSW_RST = 32'h0000_0020,
  localparam int HALF = XLEN / 2
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [EV_N-1:0]     grant,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     cur_psw,
  input  logic [HALF-1:0]     exc_code,
  input  logic [HALF-1:0]     nmi_code,
  output logic [XLEN-1:0]     exc_pc_q,
  output logic [XLEN-1:0]     exc_psw_q,
  output logic [XLEN-1:0]     nmi_pc_q,
  output logic [XLEN-1:0]     nmi_psw_q,
  output logic [XLEN-1:0]     cause_q,
  output logic [XLEN-1:0]     psw_q,
  output logic [XLEN-1:0]     tcl_pc_q,
  output logic [XLEN-1:0]     tcl_psw_q,
  output logic [XLEN-1:0]     trp_pc_q,
  output logic [XLEN-1:0]     trp_psw_q,
  output logic [XLEN-1:0]     tbase_q
);
  // Exception pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_pc_q  <= '0;
      exc_psw_q <= '0;
    end else if (grant[EVB_EXC]) begin
      exc_pc_q  <= cur_pc;
      exc_psw_q <= cur_psw;
    end else begin
      if (wr_sel[RN_EXC_PC])  exc_pc_q  <= wr_data;
      if (wr_sel[RN_EXC_PSW]) exc_psw_q <= wr_data;
    end
  end

  // NMI pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pc_q  <= '0;
      nmi_psw_q <= '0;
    end else if (grant[EVB_NMI]) begin
      nmi_pc_q  <= cur_pc;
      nmi_psw_q <= cur_psw;
    end else begin
      if (wr_sel[RN_NMI_PC])  nmi_pc_q  <= wr_data;
      if (wr_sel[RN_NMI_PSW]) nmi_psw_q <= wr_data;
    end
  end

  // Cause register: two halves, hardware only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else begin
      if (grant[EVB_EXC]) cause_q[HALF-1:0]    <= exc_code;
      if (grant[EVB_NMI]) cause_q[XLEN-1:HALF] <= nmi_code;
    end
  end

  // Status word: software only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              psw_q <= PSW_RST;
    else if (wr_sel[RN_PSW]) psw_q <= wr_data;
  end

  // Table-call pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcl_pc_q  <= '0;
      tcl_psw_q <= '0;
    end else if (grant[EVB_TCL]) begin
      tcl_pc_q  <= cur_pc;
      tcl_psw_q <= cur_psw;
    end else begin
      if (wr_sel[RN_TCL_PC])  tcl_pc_q  <= wr_data;
      if (wr_sel[RN_TCL_PSW]) tcl_psw_q <= wr_data;
    end
  end

  // Trap pair: hardware only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trp_pc_q  <= '0;
      trp_psw_q <= '0;
    end else if (grant[EVB_TRAP]) begin
      trp_pc_q  <= cur_pc;
      trp_psw_q <= cur_psw;
    end
  end

  // Table base pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tbase_q <= '0;
    else if (wr_sel[RN_TBASE]) tbase_q <= wr_data;
  end
endmodule

// File: rtl/sysreg_rdmux.sv
module sysreg_rdmux
  import sysreg_pkg::*;
#(
  parameter int XLEN = 32
)(
  input  logic [NUM_W-1:0] rd_num,
  input  logic [XLEN-1:0]  exc_pc_q,
  input  logic [XLEN-1:0]  exc_psw_q,
  input  logic [XLEN-1:0]  nmi_pc_q,
  input  logic [XLEN-1:0]  nmi_psw_q,
  input  logic [XLEN-1:0]  cause_q,
  input  logic [XLEN-1:0]  psw_q,
  input  logic [XLEN-1:0]  tcl_pc_q,
  input  logic [XLEN-1:0]  tcl_psw_q,
  input  logic [XLEN-1:0]  trp_pc_q,
  input  logic [XLEN-1:0]  trp_psw_q,
  input  logic [XLEN-1:0]  tbase_q,
  output logic [XLEN-1:0]  rd_data
);
  always_comb begin
    rd_data = '0;
    if (num_readable(rd_num)) begin
      case (rd_num)
        RN_EXC_PC:  rd_data = exc_pc_q;
        RN_EXC_PSW: rd_data = exc_psw_q;
        RN_NMI_PC:  rd_data = nmi_pc_q;
        RN_NMI_PSW: rd_data = nmi_psw_q;
        RN_CAUSE:   rd_data = cause_q;
        RN_PSW:     rd_data = psw_q;
        RN_TCL_PC:  rd_data = tcl_pc_q;
        RN_TCL_PSW: rd_data = tcl_psw_q;
        RN_TRP_PC:  rd_data = trp_pc_q;
        RN_TRP_PSW: rd_data = trp_psw_q;
        RN_TBASE:   rd_data = tbase_q;
        default:    rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] PSW_RST = 32'h0000_0020,
  localparam int HALF = XLEN / 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [NUM_W-1:0] rd_num,
  output logic [XLEN-1:0]  rd_data,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_psw,
  input  logic             ev_exc,
  input  logic [HALF-1:0]  exc_code,
  input  logic             ev_nmi,
  input  logic [HALF-1:0]  nmi_code,
  input  logic             ev_tcall,
  input  logic             ev_trap,
  output logic [XLEN-1:0]  status_word
);
  logic                wr_ok;
  logic [NUM_REGS-1:0] wr_sel;
  logic [EV_N-1:0]     grant;
  logic [XLEN-1:0] exc_pc_q, exc_psw_q, nmi_pc_q, nmi_psw_q, cause_q, psw_q;
  logic [XLEN-1:0] tcl_pc_q, tcl_psw_q, trp_pc_q, trp_psw_q, tbase_q;

  sysreg_access u_access (
    .wr_en(wr_en), .wr_num(wr_num), .wr_ok(wr_ok), .wr_sel(wr_sel)
  );

  sysreg_event_arb u_arb (
    .ev_nmi(ev_nmi), .ev_trap(ev_trap), .ev_exc(ev_exc),
    .ev_tcall(ev_tcall), .grant(grant)
  );

  sysreg_store #(.XLEN(XLEN), .PSW_RST(PSW_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
    .grant(grant), .cur_pc(cur_pc), .cur_psw(cur_psw),
    .exc_code(exc_code), .nmi_code(nmi_code),
    .exc_pc_q(exc_pc_q), .exc_psw_q(exc_psw_q),
    .nmi_pc_q(nmi_pc_q), .nmi_psw_q(nmi_psw_q),
    .cause_q(cause_q), .psw_q(psw_q),
    .tcl_pc_q(tcl_pc_q), .tcl_psw_q(tcl_psw_q),
    .trp_pc_q(trp_pc_q), .trp_psw_q(trp_psw_q), .tbase_q(tbase_q)
  );

  sysreg_rdmux #(.XLEN(XLEN)) u_rdmux (
    .rd_num(rd_num),
    .exc_pc_q(exc_pc_q), .exc_psw_q(exc_psw_q),
    .nmi_pc_q(nmi_pc_q), .nmi_psw_q(nmi_psw_q),
    .cause_q(cause_q), .psw_q(psw_q),
    .tcl_pc_q(tcl_pc_q), .tcl_psw_q(tcl_psw_q),
    .trp_pc_q(trp_pc_q), .trp_psw_q(trp_psw_q), .tbase_q(tbase_q),
    .rd_data(rd_data)
  );

  assign status_word = psw_q;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
  import sysreg_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int HALF = XLEN / 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_W-1:0] rd_num,
  input logic [XLEN-1:0]  rd_data,
  input logic [XLEN-1:0]  cur_pc,
  input logic [XLEN-1:0]  cur_psw,
  input logic [HALF-1:0]  exc_code,
  input logic [HALF-1:0]  nmi_code,
  input logic             ev_nmi,
  input logic             wr_ok,
  input logic [NUM_W-1:0] wr_num,
  input logic [EV_N-1:0]  grant,
  input logic [XLEN-1:0]  exc_pc_q,
  input logic [XLEN-1:0]  exc_psw_q,
  input logic [XLEN-1:0]  nmi_pc_q,
  input logic [XLEN-1:0]  cause_q,
  input logic [XLEN-1:0]  trp_pc_q,
  input logic [XLEN-1:0]  trp_psw_q,
  input logic [XLEN-1:0]  psw_q,
  input logic [XLEN-1:0]  status_word
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R9
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nmi |-> grant == 4'b0001);

  // R5
  exc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EVB_EXC] |=> (exc_pc_q == $past(cur_pc)) && (exc_psw_q == $past(cur_psw))
      && (cause_q[HALF-1:0] == $past(exc_code))
      && (cause_q[XLEN-1:HALF] == $past(cause_q[XLEN-1:HALF])));

  // R6
  nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EVB_NMI] |=> (nmi_pc_q == $past(cur_pc))
      && (cause_q[XLEN-1:HALF] == $past(nmi_code))
      && (cause_q[HALF-1:0] == $past(cause_q[HALF-1:0])));

  // R8
  trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EVB_TRAP] |=> (trp_pc_q == $past(cur_pc)) && (trp_psw_q == $past(cur_psw)));

  // R3
  trap_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[EVB_TRAP] |=> $stable(trp_pc_q) && $stable(trp_psw_q));

  // R3
  cause_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant[EVB_EXC] && !grant[EVB_NMI]) |=> $stable(cause_q));

  // R4
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> num_writable(wr_num));

  // R4
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !num_readable(rd_num) |-> rd_data == '0);

  // R11
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word == psw_q);
endmodule

bind sysreg_bank sysreg_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_data(rd_data),
  .cur_pc(cur_pc), .cur_psw(cur_psw), .exc_code(exc_code),
  .nmi_code(nmi_code), .ev_nmi(ev_nmi), .wr_ok(wr_ok), .wr_num(wr_num),
  .grant(grant), .exc_pc_q(exc_pc_q), .exc_psw_q(exc_psw_q),
  .nmi_pc_q(nmi_pc_q), .cause_q(cause_q), .trp_pc_q(trp_pc_q),
  .trp_psw_q(trp_psw_q), .psw_q(psw_q), .status_word(status_word)
);

// File: tb/sysreg_bank_tb_top.sv
module sysreg_bank_tb_top;
  localparam logic [31:0] PSW_INIT = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_num = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_num = '0;
  logic [31:0] rd_data;
  logic [31:0] cur_pc = '0, cur_psw = '0;
  logic        ev_exc = 1'b0, ev_nmi = 1'b0, ev_tcall = 1'b0, ev_trap = 1'b0;
  logic [15:0] exc_code = '0, nmi_code = '0;
  logic [31:0] status_word;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] mdl [32];

  typedef struct { logic [31:0] exp; string tag; int num; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sysreg_bank #(.PSW_RST(PSW_INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num),
    .wr_data(wr_data), .rd_num(rd_num), .rd_data(rd_data),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .ev_exc(ev_exc),
    .exc_code(exc_code), .ev_nmi(ev_nmi), .nmi_code(nmi_code),
    .ev_tcall(ev_tcall), .ev_trap(ev_trap), .status_word(status_word)
  );

  function automatic bit may_write(input int n);
    return (n <= 3) || (n == 5) || (n == 16) || (n == 17) || (n == 20);
  endfunction

  // Monitor: compare queued expectations shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (rd_data !== it.exp) begin
          bad++;
          $display("FAIL %s reg %0d: actual=%h expected=%h", it.tag, it.num, rd_data, it.exp);
        end
      end
    end
  end

  task automatic rd_check(input int n, input string tag);
    @(negedge clk);
    rd_num = 5'(n);
    q.push_back('{exp: mdl[n], tag: tag, num: n});
  endtask

  task automatic sweep(input string tag);
    for (int n = 0; n < 32; n++) rd_check(n, tag);
  endtask

  task automatic sw_write(input int n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 5'(n); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (may_write(n)) mdl[n] = d;
  endtask

  // ev = {nmi, trap, exc, tcall}; optional simultaneous write
  task automatic fire(input logic [3:0] ev, input logic [31:0] pc,
                      input logic [31:0] psw, input logic [15:0] ec,
                      input logic [15:0] nc, input bit do_wr,
                      input int wn, input logic [31:0] wd);
    @(negedge clk);
    {ev_nmi, ev_trap, ev_exc, ev_tcall} = ev;
    cur_pc = pc; cur_psw = psw; exc_code = ec; nmi_code = nc;
    wr_en = do_wr; wr_num = 5'(wn); wr_data = wd;
    @(negedge clk);
    {ev_nmi, ev_trap, ev_exc, ev_tcall} = 4'b0;
    wr_en = 1'b0;
    if (do_wr && may_write(wn)) mdl[wn] = wd;
    if (ev[3]) begin
      mdl[2] = pc; mdl[3] = psw; mdl[4][31:16] = nc;
    end else if (ev[2]) begin
      mdl[18] = pc; mdl[19] = psw;
    end else if (ev[1]) begin
      mdl[0] = pc; mdl[1] = psw; mdl[4][15:0] = ec;
    end else if (ev[0]) begin
      mdl[16] = pc; mdl[17] = psw;
    end
  endtask

  task automatic chk_status(input string tag);
    @(negedge clk);
    #3;
    total++;
    if (status_word !== mdl[5]) begin
      bad++;
      $display("FAIL %s status_word: actual=%h expected=%h", tag, status_word, mdl[5]);
    end
  endtask

  initial begin
    for (int n = 0; n < 32; n++) mdl[n] = '0;
    mdl[5] = PSW_INIT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    sweep("R1");
    chk_status("R11");

    // R2 writable numbers with distinct data
    for (int n = 0; n < 32; n++)
      if (may_write(n)) sw_write(n, 32'hA500_0000 + n * 32'h0101_0011);
    sweep("R2");
    chk_status("R11");

    // R3 locked registers: cause and trap pair
    sw_write(4, 32'hDEAD_BEEF);
    sw_write(18, 32'h1234_5678);
    sw_write(19, 32'h8765_4321);
    rd_check(4, "R3"); rd_check(18, "R3"); rd_check(19, "R3");

    // R4 reserved numbers
    for (int n = 6; n < 16; n++) sw_write(n, 32'hC0DE_0000 + n);
    for (int n = 21; n < 32; n++) sw_write(n, 32'hC0DE_1000 + n);
    sweep("R4");

    // R5 exception
    fire(4'b0010, 32'h0000_1000, 32'h0000_00A1, 16'h0011, 16'hFFFF, 0, 0, 0);
    rd_check(0, "R5"); rd_check(1, "R5"); rd_check(4, "R5");
    // R6 NMI, lower cause half kept
    fire(4'b1000, 32'h0000_2000, 32'h0000_00B2, 16'hEEEE, 16'h0022, 0, 0, 0);
    rd_check(2, "R6"); rd_check(3, "R6"); rd_check(4, "R6");
    // R7 table-call
    fire(4'b0001, 32'h0000_3000, 32'h0000_00C3, 16'h0, 16'h0, 0, 0, 0);
    rd_check(16, "R7"); rd_check(17, "R7");
    // R8 trap
    fire(4'b0100, 32'h0000_4000, 32'h0000_00D4, 16'h0, 16'h0, 0, 0, 0);
    rd_check(18, "R8"); rd_check(19, "R8");
    // R5 second exception keeps upper half from NMI
    fire(4'b0010, 32'h0000_5000, 32'h0000_00E5, 16'h0055, 16'h0, 0, 0, 0);
    rd_check(4, "R5");

    // R12 repeated same-class events
    fire(4'b0100, 32'h0000_6000, 32'h0000_0006, 16'h0, 16'h0, 0, 0, 0);
    fire(4'b0100, 32'h0000_7000, 32'h0000_0007, 16'h0, 16'h0, 0, 0, 0);
    rd_check(18, "R12"); rd_check(19, "R12");
    fire(4'b0001, 32'h0000_7100, 32'h0000_0071, 16'h0, 16'h0, 0, 0, 0);
    fire(4'b0001, 32'h0000_7200, 32'h0000_0072, 16'h0, 16'h0, 0, 0, 0);
    rd_check(16, "R12");

    // R9 priority under simultaneous events
    fire(4'b1111, 32'h0000_8000, 32'h0000_0080, 16'h0088, 16'h0099, 0, 0, 0);
    sweep("R9");
    fire(4'b0111, 32'h0000_9000, 32'h0000_0090, 16'h00AA, 16'h0, 0, 0, 0);
    sweep("R9");
    fire(4'b0011, 32'h0000_A000, 32'h0000_00A0, 16'h00BB, 16'h0, 0, 0, 0);
    sweep("R9");

    // R10 capture beats software write to the same register
    fire(4'b0010, 32'h0000_B000, 32'h0000_00B0, 16'h00CC, 16'h0, 1, 0, 32'hFFFF_0000);
    rd_check(0, "R10");
    fire(4'b0001, 32'h0000_C000, 32'h0000_00C0, 16'h0, 16'h0, 1, 17, 32'hFFFF_1111);
    rd_check(17, "R10");
    // write to an unrelated register in the same cycle still lands
    fire(4'b1000, 32'h0000_D000, 32'h0000_00D0, 16'h0, 16'h00DD, 1, 20, 32'h0BAD_F00D);
    sweep("R10");

    // R11 status word follows writes
    sw_write(5, 32'h0000_0F0F);
    chk_status("R11");
    rd_check(5, "R11");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule